// File: doc/BRIEF.md
# Audio Clock Regeneration Controller

This block rebuilds an audio master clock from the TMDS-rate reference clock. Each incoming audio clock regeneration packet carries an N and a CTS value. A digital numerically controlled oscillator runs on the reference clock and adds N to a phase accumulator on every cycle. Whenever the accumulator reaches CTS, CTS is subtracted and a one-cycle enable pulse is issued. The pulse train `mclk_en` therefore runs at f_TMDS × N / CTS, which is 128 times the audio sampling rate. Logic downstream uses `mclk_en` as the clock enable for its audio processing.

The active N/CTS pair is replaced automatically when a packet brings a different value. Software can also force a reload through a self-clearing control, and a reload restarts the loop. The `locked` flag rises only after two conditions both hold: the TMDS PLL reports lock, and an in-range pair has been accepted. Once that happens it rises within two master-clock periods.

A mask selects which coast events count. While any selected event is active, the block freezes its parameters and its lock flag and keeps producing the same pulse train for as long as the event lasts.

Top module: `acr_clock_regen`

## Requirements
- R1: With an accepted pair (N, CTS) and no reload, the number of `mclk_en` pulses over any window of W reference cycles lies within 1 of W·N/CTS, and each pulse lasts one cycle.
- R2: A packet is in range only if N ≠ 0, CTS ≠ 0 and N ≤ CTS. An out-of-range packet is ignored: it causes no reload, the pulse rate does not change and `locked` does not change.
- R3: While no pair has been accepted, or while `tmds_pll_ok` is low with no coast active, `locked` stays 0 and `mclk_en` stays 0.
- R4: Once both prerequisites hold, `locked` rises on the clock edge that samples the second `mclk_en` pulse, so it reads 1 one reference cycle after that pulse. It never rises earlier.
- R5: A packet whose N or CTS differs from the active pair is loaded. `locked` reads 0 two cycles after the packet, and the rate then follows the new pair. A packet identical to the active pair causes no reload, and `locked` stays 1.
- R6: `force_reload` = 1 for one cycle, with a pair held, reloads that same pair. This restarts the accumulator, clears `locked`, and `mclk_en` is 0 in the cycle after the reload. Holding `force_reload` at 0 has no effect.
- R7: While `coast_evt & coast_mask` is nonzero, the pulse rate and `locked` are held. Packets, `force_reload` and loss of `tmds_pll_ok` are all ignored, for any duration.
- R8: If `tmds_pll_ok` falls while no coast is active, `locked` reads 0 and pulses stop by the next cycle. After the PLL recovers, a fresh in-range packet is needed to lock again, even if its values are the old ones.
- R9: After reset, `locked` = 0 and `mclk_en` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_tmds | input | 1 | TMDS-rate reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmds_pll_ok | input | 1 | TMDS clock PLL lock indication |
| acr_valid | input | 1 | One-cycle strobe: acr_n/acr_cts hold a packet |
| acr_n | input | 20 | N value of the packet |
| acr_cts | input | 20 | CTS value of the packet |
| force_reload | input | 1 | Self-clearing forced parameter reload, active 1 |
| coast_evt | input | EVT_W (4) | Coast event inputs |
| coast_mask | input | EVT_W (4) | Coast event enables |
| mclk_en | output | 1 | Master-clock enable pulse train at 128·fs |
| locked | output | 1 | Regeneration lock status, 1 = locked |

## Verification
The bench builds the block with its defaults: 20-bit N and CTS fields, four coast events and a lock delay of two pulses. It uses small ratios such as 3/16, 1/8 and 1/1. With these, the exact lock edge, the restart after a reload and rate windows of a few hundred pulses all fit in short runs. The N > CTS and zero-field packets probe the range limits, and coasting across a PLL loss shows that the lock and the rate are held.

// File: rtl/acr_pkg.sv
// Package: shared field width, parameter-pair type and range qualification
// for the audio clock regeneration controller.
package acr_pkg;
    localparam int ACR_W = 20;

    typedef struct packed {
        logic [ACR_W-1:0] n;
        logic [ACR_W-1:0] cts;
    } acr_pair_t;

    // A pair is usable only when both fields are nonzero and N does not exceed CTS
    function automatic logic acr_in_range(input acr_pair_t p);
        return (p.n != '0) && (p.cts != '0) && (p.n <= p.cts);
    endfunction
endpackage

// File: rtl/acr_param_loader.sv
// Holds the active N/CTS pair. Loads a new in-range pair when it differs
// from the active one (or none is held), reloads on a forced update, drops
// the pair on PLL loss, and freezes all state while coasting.
// Assumes: packets are single-cycle strobes in the reference clock domain.
module acr_param_loader
    import acr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pll_ok,
    input  logic      coast,
    input  logic      pkt_valid,
    input  acr_pair_t pkt,
    input  logic      force_reload,
    output acr_pair_t active,
    output logic      have_pair,
    output logic      reload
);
    logic pkt_ok;
    logic differs;

    // Qualify an incoming packet against range and the active pair
    always_comb begin
        pkt_ok  = pkt_valid && acr_in_range(pkt);
        differs = !have_pair || (pkt != active);
    end

    // Parameter register with reload pulse generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= '0;
            have_pair <= 1'b0;
            reload    <= 1'b0;
        end else begin
            reload <= 1'b0;
            if (coast) begin
                reload <= 1'b0;
            end else if (!pll_ok) begin
                have_pair <= 1'b0;
            end else if (pkt_ok && differs) begin
                active    <= pkt;
                have_pair <= 1'b1;
                reload    <= 1'b1;
            end else if (force_reload && have_pair) begin
                reload <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/acr_nco.sv
// Phase accumulator oscillator: adds N each cycle, subtracts CTS and emits
// one enable pulse whenever the sum reaches CTS. Restarts from zero phase
// on reload. Assumes N <= CTS, so at most one pulse is due per cycle.
module acr_nco
    import acr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  logic      reload,
    input  acr_pair_t pair,
    output logic      pulse
);
    logic [ACR_W-1:0] phase;
    logic [ACR_W:0]   sum;

    // Next phase before wrap
    always_comb sum = {1'b0, phase} + {1'b0, pair.n};

    // Accumulate, wrap at CTS and register the enable pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            pulse <= 1'b0;
        end else if (reload) begin
            phase <= '0;
            pulse <= 1'b0;
        end else if (run) begin
            if (sum >= {1'b0, pair.cts}) begin
                phase <= ACR_W'(sum - {1'b0, pair.cts});
                pulse <= 1'b1;
            end else begin
                phase <= sum[ACR_W-1:0];
                pulse <= 1'b0;
            end
        end else begin
            pulse <= 1'b0;
        end
    end
endmodule

// File: rtl/acr_lock_ctrl.sv
// Lock qualification: while a pair is held, the PLL is locked and no reload
// is in progress, counts master-clock pulses and declares lock on pulse
// LOCK_DLY. Holds everything while coasting. Assumes LOCK_DLY >= 1.
module acr_lock_ctrl #(
    parameter int LOCK_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic coast,
    input  logic have_pair,
    input  logic pll_ok,
    input  logic reload,
    input  logic pulse,
    output logic locked
);
    localparam int CW = $clog2(LOCK_DLY + 1);

    logic [CW-1:0] seen;
    logic          qualified;

    // Both prerequisites present and loop not restarting
    always_comb qualified = have_pair && pll_ok && !reload;

    // Pulse counter and lock flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen   <= '0;
            locked <= 1'b0;
        end else if (coast) begin
            seen   <= seen;
        end else if (!qualified) begin
            seen   <= '0;
            locked <= 1'b0;
        end else if (!locked && pulse) begin
            if (seen == CW'(LOCK_DLY - 1)) begin
                locked <= 1'b1;
            end else begin
                seen <= seen + 1'b1;
            end
        end
    end
endmodule

// File: rtl/acr_clock_regen.sv
// Top level of the audio clock regeneration controller. Reduces the masked
// coast events, then wires the parameter loader, the oscillator and the
// lock qualifier. Assumes all inputs are synchronous to clk_tmds.
module acr_clock_regen
    import acr_pkg::*;
#(
    parameter int EVT_W    = 4,
    parameter int LOCK_DLY = 2
) (
    input  logic             clk_tmds,
    input  logic             rst_n,
    input  logic             tmds_pll_ok,
    input  logic             acr_valid,
    input  logic [ACR_W-1:0] acr_n,
    input  logic [ACR_W-1:0] acr_cts,
    input  logic             force_reload,
    input  logic [EVT_W-1:0] coast_evt,
    input  logic [EVT_W-1:0] coast_mask,
    output logic             mclk_en,
    output logic             locked
);
    logic      coast;
    logic      have_pair;
    logic      reload;
    logic      run;
    acr_pair_t pkt;
    acr_pair_t active;

    // Coast request and oscillator run condition
    always_comb begin
        coast = |(coast_evt & coast_mask);
        pkt   = '{n: acr_n, cts: acr_cts};
        run   = have_pair && (tmds_pll_ok || coast);
    end

    acr_param_loader u_load (
        .clk          (clk_tmds),
        .rst_n        (rst_n),
        .pll_ok       (tmds_pll_ok),
        .coast        (coast),
        .pkt_valid    (acr_valid),
        .pkt          (pkt),
        .force_reload (force_reload),
        .active       (active),
        .have_pair    (have_pair),
        .reload       (reload)
    );

    acr_nco u_nco (
        .clk    (clk_tmds),
        .rst_n  (rst_n),
        .run    (run),
        .reload (reload),
        .pair   (active),
        .pulse  (mclk_en)
    );

    acr_lock_ctrl #(.LOCK_DLY(LOCK_DLY)) u_lock (
        .clk       (clk_tmds),
        .rst_n     (rst_n),
        .coast     (coast),
        .have_pair (have_pair),
        .pll_ok    (tmds_pll_ok),
        .reload    (reload),
        .pulse     (mclk_en),
        .locked    (locked)
    );
endmodule

// File: rtl/acr_clock_regen_chk.sv
// Checker for acr_clock_regen: relates ports and the loader's outputs over time.
module acr_clock_regen_chk
    import acr_pkg::*;
#(
    parameter int EVT_W = 4
) (
    input logic             clk_tmds,
    input logic             rst_n,
    input logic             tmds_pll_ok,
    input logic             acr_valid,
    input logic [ACR_W-1:0] acr_n,
    input logic [ACR_W-1:0] acr_cts,
    input logic             force_reload,
    input logic [EVT_W-1:0] coast_evt,
    input logic [EVT_W-1:0] coast_mask,
    input logic             mclk_en,
    input logic             locked,
    input acr_pair_t        active,
    input logic             reload
);
    logic coast_on;
    always_comb coast_on = |(coast_evt & coast_mask);

    // R4
    lock_after_pulse_chk: assert property (@(posedge clk_tmds) disable iff (!rst_n)
        $rose(locked) |-> $past(mclk_en));

    // R8
    pll_loss_unlock_chk: assert property (@(posedge clk_tmds) disable iff (!rst_n)
        (!coast_on && !tmds_pll_ok) |=> !locked);

    // R7
    coast_hold_chk: assert property (@(posedge clk_tmds) disable iff (!rst_n)
        coast_on |=> ($stable(locked) && $stable(active)));

    // R6
    reload_restart_chk: assert property (@(posedge clk_tmds) disable iff (!rst_n)
        reload |=> (!mclk_en && !locked));

    // R5
    change_needs_reload_chk: assert property (@(posedge clk_tmds) disable iff (!rst_n)
        !$stable(active) |-> reload);

    // R2
    bad_packet_ignored_chk: assert property (@(posedge clk_tmds) disable iff (!rst_n)
        (acr_valid && !force_reload && !acr_in_range('{n: acr_n, cts: acr_cts}))
        |=> !reload);
endmodule

bind acr_clock_regen acr_clock_regen_chk #(.EVT_W(EVT_W)) u_chk (
    .clk_tmds     (clk_tmds),
    .rst_n        (rst_n),
    .tmds_pll_ok  (tmds_pll_ok),
    .acr_valid    (acr_valid),
    .acr_n        (acr_n),
    .acr_cts      (acr_cts),
    .force_reload (force_reload),
    .coast_evt    (coast_evt),
    .coast_mask   (coast_mask),
    .mclk_en      (mclk_en),
    .locked       (locked),
    .active       (active),
    .reload       (reload)
);

// File: tb/acr_clock_regen_bench.sv
module acr_clock_regen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 20;
    localparam int EW         = 4;

    logic          clk_tmds = 1'b0;
    logic          rst_n;
    logic          tmds_pll_ok;
    logic          acr_valid;
    logic [W-1:0]  acr_n;
    logic [W-1:0]  acr_cts;
    logic          force_reload;
    logic [EW-1:0] coast_evt;
    logic [EW-1:0] coast_mask;
    logic          mclk_en;
    logic          locked;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    acr_clock_regen u_acr_clock_regen (
        .clk_tmds     (clk_tmds),
        .rst_n        (rst_n),
        .tmds_pll_ok  (tmds_pll_ok),
        .acr_valid    (acr_valid),
        .acr_n        (acr_n),
        .acr_cts      (acr_cts),
        .force_reload (force_reload),
        .coast_evt    (coast_evt),
        .coast_mask   (coast_mask),
        .mclk_en      (mclk_en),
        .locked       (locked)
    );

    always #(CLK_PERIOD/2) clk_tmds = ~clk_tmds;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int k);
        for (int i = 0; i < k; i++) @(negedge clk_tmds);
    endtask

    task automatic send(input int n, input int cts);
        acr_n = W'(n); acr_cts = W'(cts); acr_valid = 1'b1;
        tick(1);
        acr_valid = 1'b0;
    endtask

    // Count pulses over a window; also checks pulses are single-cycle (R1)
    task automatic count_pulses(input int cyc, output int cnt, output bit wide);
        bit prev = 0;
        cnt = 0; wide = 0;
        for (int i = 0; i < cyc; i++) begin
            tick(1);
            if (mclk_en) cnt++;
            if (mclk_en && prev) wide = 1;
            prev = mclk_en;
        end
    endtask

    task automatic check_rate(input int cyc, input int n, input int cts, input string req);
        int cnt; bit wide; int exp;
        count_pulses(cyc, cnt, wide);
        exp = cyc * n / cts;
        check(cnt >= exp - 1 && cnt <= exp + 1, req, cnt, exp);
        if (n < cts) check(!wide, {req, " single-cycle"}, int'(wide), 0);
    endtask

    // Watch for lock after a load: locked must be 0 until the 2nd pulse, 1 right after (R4)
    task automatic expect_lock(input string req);
        int pulses = 0; bit early = 0; bit got = 0;
        tick(2);
        for (int i = 0; i < 200 && !got; i++) begin
            if (pulses == 2) begin
                got = 1;
            end else begin
                if (locked) early = 1;
                if (mclk_en) pulses++;
                tick(1);
            end
        end
        check(!early, {req, " no early lock"}, int'(early), 0);
        check(locked == 1'b1, {req, " lock after 2nd pulse"}, int'(locked), 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tmds_pll_ok = 1'b0; acr_valid = 1'b0; acr_n = '0; acr_cts = '0;
        force_reload = 1'b0; coast_evt = '0; coast_mask = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R9
        check(locked == 1'b0, "R9 locked", int'(locked), 0);
        check(mclk_en == 1'b0, "R9 mclk_en", int'(mclk_en), 0);
    endtask

    task automatic t_no_prereq();
        int cnt; bit wide;
        // R3: packet while PLL unlocked is not taken
        send(3, 16);
        count_pulses(60, cnt, wide);
        check(cnt == 0, "R3 no pulses without PLL", cnt, 0);
        check(locked == 1'b0, "R3 no lock without PLL", int'(locked), 0);
        // R3: PLL locked but no packet yet
        tmds_pll_ok = 1'b1;
        count_pulses(60, cnt, wide);
        check(cnt == 0, "R3 no pulses without packet", cnt, 0);
        check(locked == 1'b0, "R3 no lock without packet", int'(locked), 0);
    endtask

    task automatic t_lock_and_rate();
        send(3, 16);
        expect_lock("R4");
        check_rate(1600, 3, 16, "R1 rate 3/16");
    endtask

    task automatic t_change_and_same();
        send(1, 8);
        tick(1);
        // R5: differing pair reloads and clears lock
        check(locked == 1'b0, "R5 reload clears lock", int'(locked), 0);
        expect_lock("R5 relock");
        check_rate(800, 1, 8, "R5 rate follows new pair");
        send(1, 8);
        tick(3);
        check(locked == 1'b1, "R5 identical pair keeps lock", int'(locked), 1);
    endtask

    task automatic t_bad_packets();
        send(0, 8);
        tick(3);
        check(locked == 1'b1, "R2 zero N ignored", int'(locked), 1);
        send(5, 0);
        tick(3);
        check(locked == 1'b1, "R2 zero CTS ignored", int'(locked), 1);
        send(10, 5);
        tick(3);
        check(locked == 1'b1, "R2 N above CTS ignored", int'(locked), 1);
        check_rate(800, 1, 8, "R2 rate unchanged");
    endtask

    task automatic t_force();
        tick(40);
        check(locked == 1'b1, "R6 zero force no effect", int'(locked), 1);
        force_reload = 1'b1;
        tick(1);
        force_reload = 1'b0;
        tick(1);
        check(locked == 1'b0, "R6 force clears lock", int'(locked), 0);
        expect_lock("R6 relock");
        check_rate(800, 1, 8, "R6 same pair after force");
    endtask

    task automatic t_full_rate();
        int cnt; bit wide;
        send(5, 5);
        expect_lock("R1 N=CTS lock");
        count_pulses(100, cnt, wide);
        check(cnt == 100, "R1 N=CTS pulse every cycle", cnt, 100);
        send(1, 8);
        expect_lock("R1 back to 1/8");
    endtask

    task automatic t_coast();
        coast_mask = 4'b0010;
        coast_evt  = 4'b0100;
        tick(2);
        check(locked == 1'b1, "R7 unmasked event no coast", int'(locked), 1);
        coast_evt = 4'b0110;
        tick(1);
        tmds_pll_ok = 1'b0;
        send(3, 16);
        force_reload = 1'b1;
        tick(1);
        force_reload = 1'b0;
        tick(3);
        check(locked == 1'b1, "R7 lock held in coast", int'(locked), 1);
        check_rate(2400, 1, 8, "R7 rate held in coast");
        coast_evt = 4'b0100;
        tick(2);
        check(locked == 1'b0, "R8 coast end with PLL down unlocks", int'(locked), 0);
        coast_mask = '0; coast_evt = '0;
    endtask

    task automatic t_pll_loss();
        int cnt; bit wide;
        tmds_pll_ok = 1'b1;
        send(1, 8);
        expect_lock("R8 relock after coast");
        tmds_pll_ok = 1'b0;
        tick(1);
        check(locked == 1'b0, "R8 PLL loss unlocks next cycle", int'(locked), 0);
        count_pulses(40, cnt, wide);
        check(cnt == 0, "R8 pulses stop", cnt, 0);
        tmds_pll_ok = 1'b1;
        count_pulses(60, cnt, wide);
        check(cnt == 0 && locked == 1'b0, "R8 waits for packet", cnt, 0);
        send(1, 8);
        expect_lock("R8 same pair reaccepted");
    endtask

    initial begin
        t_reset();
        t_no_prereq();
        t_lock_and_rate();
        t_change_and_same();
        t_bad_packets();
        t_force();
        t_full_rate();
        t_coast();
        t_pll_loss();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule